// File: doc/BRIEF.md
# Filtered Interrupt Aggregator

This block merges a set of active-low interrupt request lines into one active-low interrupt output. The output is an open-drain drive-low enable: the pad drives low while the enable is high and floats otherwise. Each request line comes from outside the clock domain. It first passes through a two-flop synchronizer and then through a glitch filter whose acceptance thresholds differ by direction. A low excursion must last longer than a high one before the filter believes it.

The filtered state of every line is also exposed as a status bit, both as a plain vector and placed at fixed positions of a byte. A serial register read path can return that byte as is. A line is monitored at all times, independent of any downstream channel being enabled. Thresholds are given in clock cycles. With the default 250 MHz clock, 250 cycles reject low pulses below 1 us and 125 cycles reject high glitches below 0.5 us. The worst-case latencies stay well inside 4 us for assertion and 2 us for release.

Top module: `irq_aggregator`

## Requirements
- R1: While reset is asserted and right after it is released with all lines high, every status bit is 0, the drive-low enable is 0 and the read byte is 0x00.
- R2: The drive-low enable is 1 exactly one cycle after at least one filtered status bit is 1, and 0 one cycle after all status bits are 0.
- R3: A low pulse on a line that is sampled low by fewer than LOW_CYC consecutive clock edges changes neither the status nor the output. A second short pulse after a one-cycle high gap is also rejected, because the count restarts.
- R4: A line sampled low at LOW_CYC or more consecutive edges sets its status bit after exactly LOW_CYC+2 edges and the drive-low enable after LOW_CYC+3 edges. Both latencies are counted from the first edge that samples it low.
- R5: While a status bit is set, a high glitch sampled by fewer than HIGH_CYC consecutive edges leaves that bit and the output unchanged.
- R6: A line sampled high at HIGH_CYC or more consecutive edges clears its status bit after exactly HIGH_CYC+2 edges. When it was the last active line, the drive-low enable is cleared after HIGH_CYC+3 edges.
- R7: Lines are filtered independently. Several can be active at once, and status bit i reflects line i only.
- R8: In the read byte, bit 4 carries the status of line 0 and bit 5 the status of line 1 (1 = interrupt active). All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_n_i | input | NUM_SRC | Raw active-low interrupt requests, asynchronous |
| irq_drive_low_o | output | 1 | Open-drain enable: 1 pulls the interrupt output low |
| irq_active_o | output | NUM_SRC | Filtered status per line, 1 = active |
| rd_status_o | output | RD_W | Read byte with status bits at STAT_LSB upward, rest 0 |

## Verification
The bound-latency properties assume the raw request lines change at most once per clock period. They also assume a run length counted on the raw port is a faithful picture of what the synchronizer sees two cycles later. The stimulus respects both by changing every line only on the falling clock edge, one level per cycle. Pulse widths are chosen on both sides of each threshold, one cycle short and exactly at it.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    // Electrical level of a request line
    typedef enum logic {
        LVL_ACTIVE = 1'b0,
        LVL_IDLE   = 1'b1
    } irq_lvl_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{s1: RST_VAL, s2: RST_VAL};
        else         st_q <= st_d;
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/irqagg_filter.sv
module irqagg_filter
    import irqagg_pkg::*;
#(
    parameter int unsigned LOW_CYC  = 250,
    parameter int unsigned HIGH_CYC = 125
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,      // synchronized, active low
    output logic active_o    // filtered, 1 = request active
);
    localparam int unsigned CMAX = max2(LOW_CYC, HIGH_CYC);
    localparam int unsigned CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] LOW_LIM  = CW'(LOW_CYC - 1);
    localparam logic [CW-1:0] HIGH_LIM = CW'(HIGH_CYC - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        logic          want;
        logic [CW-1:0] lim;
        st_d = st_q;
        want = (lvl_i == LVL_ACTIVE);
        lim  = want ? LOW_LIM : HIGH_LIM;
        if (want == st_q.active) begin
            st_d.cnt = '0;                  // level agrees: restart the count
        end else if (st_q.cnt == lim) begin
            st_d.active = want;             // stable long enough: accept
            st_d.cnt    = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{active: 1'b0, cnt: '0};
        else         st_q <= st_d;
    end

    assign active_o = st_q.active;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
    parameter int unsigned NUM_SRC  = 2,
    parameter int unsigned LOW_CYC  = 250,
    parameter int unsigned HIGH_CYC = 125,
    parameter int unsigned STAT_LSB = 4,
    parameter int unsigned RD_W     = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] irq_n_i,
    output logic               irq_drive_low_o,
    output logic [NUM_SRC-1:0] irq_active_o,
    output logic [RD_W-1:0]    rd_status_o
);
    typedef struct packed {
        logic drive;
    } out_t;

    logic [NUM_SRC-1:0] lvl_sync;
    logic [NUM_SRC-1:0] act;
    out_t               out_d, out_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        irqagg_sync #(.RST_VAL(1'b1)) u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .d_i    (irq_n_i[g]),
            .q_o    (lvl_sync[g])
        );
        irqagg_filter #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_filt (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .lvl_i    (lvl_sync[g]),
            .active_o (act[g])
        );
    end

    always_comb begin
        out_d       = out_q;
        out_d.drive = |act;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '{drive: 1'b0};
        else         out_q <= out_d;
    end

    always_comb begin
        rd_status_o                       = '0;
        rd_status_o[STAT_LSB +: NUM_SRC]  = act;
    end

    assign irq_active_o    = act;
    assign irq_drive_low_o = out_q.drive;
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker #(
    parameter int unsigned NUM_SRC  = 2,
    parameter int unsigned LOW_CYC  = 250,
    parameter int unsigned HIGH_CYC = 125,
    parameter int unsigned STAT_LSB = 4,
    parameter int unsigned RD_W     = 8
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_SRC-1:0] irq_n_i,
    input logic               irq_drive_low_o,
    input logic [NUM_SRC-1:0] irq_active_o,
    input logic [RD_W-1:0]    rd_status_o
);
    localparam int unsigned LSAT = LOW_CYC + 3;
    localparam int unsigned HSAT = HIGH_CYC + 3;
    localparam int unsigned RW   = $clog2(((LSAT > HSAT) ? LSAT : HSAT) + 1);

    logic [NUM_SRC-1:0] low_long, low_out, high_long, high_out;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_run
        logic [RW-1:0] low_run, high_run;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                low_run  <= '0;
                high_run <= '0;
            end else begin
                if (irq_n_i[g]) low_run <= '0;
                else if (low_run != RW'(LSAT)) low_run <= low_run + 1'b1;
                if (!irq_n_i[g]) high_run <= '0;
                else if (high_run != RW'(HSAT)) high_run <= high_run + 1'b1;
            end
        end
        assign low_long[g]  = (low_run  >= RW'(LOW_CYC + 2));
        assign low_out[g]   = (low_run  >= RW'(LOW_CYC + 3));
        assign high_long[g] = (high_run >= RW'(HIGH_CYC + 2));
        assign high_out[g]  = (high_run >= RW'(HIGH_CYC + 3));

        p_low_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            low_long[g] |-> irq_active_o[g]);
        p_high_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            high_long[g] |-> !irq_active_o[g]);
    end

    p_or_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|irq_active_o) |=> irq_drive_low_o);
    p_or_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(|irq_active_o) |=> !irq_drive_low_o);
    p_out_assert_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|low_out) |-> irq_drive_low_o);
    p_out_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (&high_out) |-> !irq_drive_low_o);

    // R1: held state during reset
    always @(posedge clk_i) begin
        if (!rst_ni) begin
            p_reset_idle_r1: assert (!irq_drive_low_o && irq_active_o == '0 && rd_status_o == '0);
        end
    end
endmodule

bind irq_aggregator irqagg_checker #(
    .NUM_SRC(NUM_SRC), .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC),
    .STAT_LSB(STAT_LSB), .RD_W(RD_W)
) u_chk (.*);

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
    localparam int L = 250;
    localparam int H = 125;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] irq_n = 2'b11;
    logic       drv;
    logic [1:0] act;
    logic [7:0] rd;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2 clk = ~clk;

    irq_aggregator #(.NUM_SRC(2), .LOW_CYC(L), .HIGH_CYC(H), .STAT_LSB(4), .RD_W(8)) u_irq_aggregator (
        .clk_i(clk), .rst_ni(rst_n), .irq_n_i(irq_n),
        .irq_drive_low_o(drv), .irq_active_o(act), .rd_status_o(rd)
    );

    task automatic chk(input string tag, input int actv, input int expv);
        n_chk++;
        if (actv != expv) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, actv, expv);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Wait n cycles, return 1 if status or output ever moved off the idle state
    task automatic watch_idle(input int n, inout logic seen);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (drv || act != 2'b00) seen = 1'b1;
        end
    endtask

    task automatic t_reset_r1();
        rst_n = 1'b0; irq_n = 2'b11;
        step(3);
        chk("R1 drive in reset", drv, 0);
        chk("R1 byte in reset", rd, 8'h00);
        rst_n = 1'b1;
        step(3);
        chk("R1 drive after reset", drv, 0);
        chk("R1 status after reset", act, 0);
    endtask

    task automatic t_short_low_r3();
        logic seen = 1'b0;
        irq_n[0] = 1'b0; watch_idle(L - 1, seen);
        irq_n[0] = 1'b1; watch_idle(L + 10, seen);
        chk("R3 short low src0", seen, 0);
        seen = 1'b0;
        irq_n[1] = 1'b0; watch_idle(L - 1, seen);
        irq_n[1] = 1'b1; watch_idle(1, seen);
        irq_n[1] = 1'b0; watch_idle(L - 1, seen);
        irq_n[1] = 1'b1; watch_idle(L + 10, seen);
        chk("R3 two short lows with restart src1", seen, 0);
        chk("R3 byte after short lows", rd, 8'h00);
    endtask

    task automatic t_assert_r4();
        irq_n[0] = 1'b0;
        step(L + 1);
        chk("R4 status not yet set", act[0], 0);
        step(1);
        chk("R4 status set at L+2", act[0], 1);
        chk("R8 byte src0 at bit4", rd, 8'h10);
        chk("R2 drive lags status", drv, 0);
        step(1);
        chk("R4 drive at L+3", drv, 1);
    endtask

    task automatic t_short_high_r5();
        logic seen = 1'b0;
        irq_n[0] = 1'b1;
        for (int i = 0; i < H - 1; i++) begin
            @(negedge clk); if (!act[0] || !drv) seen = 1'b1;
        end
        irq_n[0] = 1'b0;
        for (int i = 0; i < H + 10; i++) begin
            @(negedge clk); if (!act[0] || !drv) seen = 1'b1;
        end
        chk("R5 short high glitch ignored", seen, 0);
    endtask

    task automatic t_release_r6();
        irq_n[0] = 1'b1;
        step(H + 1);
        chk("R6 status still set", act[0], 1);
        step(1);
        chk("R6 status cleared at H+2", act[0], 0);
        chk("R6 drive still low one cycle", drv, 1);
        step(1);
        chk("R6 drive released at H+3", drv, 0);
    endtask

    task automatic t_exact_min_r4();
        irq_n[1] = 1'b0;
        step(L);
        irq_n[1] = 1'b1;
        step(2);
        chk("R4 pulse of exactly L accepted", rd, 8'h20);
        step(H + 5);
        chk("R6 cleared after exact pulse", rd, 8'h00);
        chk("R6 drive released after exact pulse", drv, 0);
    endtask

    task automatic t_both_r7();
        irq_n[1] = 1'b0;
        step(L + 5);
        chk("R7 src1 only", rd, 8'h20);
        chk("R2 drive with src1", drv, 1);
        irq_n[0] = 1'b0;
        step(L + 5);
        chk("R7 both active", rd, 8'h30);
        irq_n[1] = 1'b1;
        step(H + 5);
        chk("R7 src1 released src0 kept", rd, 8'h10);
        chk("R2 drive held by src0", drv, 1);
        irq_n[0] = 1'b1;
        step(H + 5);
        chk("R7 all released", rd, 8'h00);
        chk("R2 drive released", drv, 0);
    endtask

    initial begin
        step(1);
        t_reset_r1();
        t_short_low_r3();
        t_assert_r4();
        t_short_high_r5();
        t_release_r6();
        t_exact_min_r4();
        t_both_r7();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule